// File: doc/BRIEF.md
# Master/Slave Audio Clock Generator

This block produces the serial-audio bit clock and frame clock from a system master clock. The master clock runs at 256 times the sample rate. When the block is master, it divides that clock down to a bit clock of 32 or 64 times the frame rate. It drives a frame clock whose period is one stereo sample, which is 256 master clocks. When the block is slave, it releases both pins by dropping their output enables. An external device then supplies the clocks, and the block only observes the incoming frame clock.

Two inputs decide the role together: a board strap and a configuration bit. A small state machine moves through three named states. `MODE_SLAVE` is the reset state. It goes to `MODE_ALIGN` when both inputs are high. `MODE_ALIGN` clears the dividers and always goes to `MODE_MASTER` on the next edge if the request still holds, or back to `MODE_SLAVE` if it does not. `MODE_MASTER` returns to `MODE_SLAVE` as soon as the request drops.

The block also has two extra outputs. One is a gated copy of the master clock, which is enabled by the strap and can be stopped by a control bit. The other is an open-drain-style watchdog output. It toggles after a programmable number of frame-clock rising edges, so it goes quiet whenever frames stop arriving.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is held, and in the first cycle after it, the following outputs are all low: `bck_out`, `lrck_out`, `bck_oe`, `lrck_oe` and `wdc_pull_low`.
- R2: The enables `bck_oe` and `lrck_oe` are high only in master mode. Master mode needs both `strap_hi` and `cfg_master` high. In any other case both enables are low and `bck_out` and `lrck_out` are held at 0.
- R3: Suppose the request (`strap_hi` and `cfg_master` both high) is first seen at clock edge E. Then `bck_oe` rises after edge E+1. In that first enabled cycle, `bck_out` and `lrck_out` are both 0.
- R4: With `cfg_bck64`=1, let k be the count of clock edges since the first enabled cycle. Then `bck_out` equals bit 1 of k, giving a period of 4 clocks. `lrck_out` equals bit 7 of k, giving a period of 256 clocks.
- R5: With `cfg_bck64`=0, `bck_out` equals bit 2 of k, giving a period of 8 clocks. `lrck_out` is unchanged from R4.
- R6: In master mode, every transition of `lrck_out` happens in the same cycle as a falling edge of `bck_out`.
- R7: If the request drops, both enables fall after the next clock edge. A later request starts again through R3, with the count reset to 0.
- R8: `mck_oe` equals `strap_hi`. `mck_out` follows `clk_sys` while `strap_hi`=1 and `cfg_mck_stop`=0, and is 0 otherwise. A change to the run condition takes effect at the next falling edge of `clk_sys`.
- R9: The watchdog counts rising edges of the active frame clock. In master mode this is the internal frame clock. In slave mode it is `lrck_in`, passed through two synchronizer flops. After `wd_period` rising edges, `wdc_pull_low` toggles. A rise on `lrck_in` toggles the output 3 clock edges later.
- R10: If no frame-clock rising edge occurs, `wdc_pull_low` holds its value.
- R11: When `wd_period` is 0, `wdc_pull_low` is 0 from the next clock edge onward, and the frame count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_hi | input | 1 | Board strap; high permits master mode and the master-clock output |
| cfg_master | input | 1 | Configuration bit requesting master mode |
| cfg_bck64 | input | 1 | 1: bit clock at 64fs; 0: bit clock at 32fs |
| cfg_mck_stop | input | 1 | 1 stops the gated master-clock output |
| wd_period | input | WD_W | Frame edges per watchdog half-period; 0 disables the watchdog |
| lrck_in | input | 1 | External frame clock, used in slave mode |
| bck_out | output | 1 | Generated bit clock |
| bck_oe | output | 1 | Output enable for the bit-clock pin |
| lrck_out | output | 1 | Generated frame clock |
| lrck_oe | output | 1 | Output enable for the frame-clock pin |
| mck_out | output | 1 | Gated copy of `clk_sys` |
| mck_oe | output | 1 | Output enable for the master-clock pin |
| wdc_pull_low | output | 1 | 1 pulls the watchdog line low; 0 releases it |

## Verification
Each result has a fixed latency, and each check samples at that point:

- **Enables:** they respond one edge after a request change when leaving master mode, and two edges after it when entering.
- **Divided clocks:** they are then compared every cycle against bits of a count the bench keeps itself, starting from the first enabled cycle.
- **Watchdog:** it is checked three edges after an external frame rise, and at exact frame numbers in master mode.
- **Gated master clock:** it is sampled a quarter period into each clock phase, with one falling edge allowed for a stop or start to take effect.

All inputs change just after a rising edge, and outputs are sampled at the falling edge.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
    typedef enum logic [1:0] {
        MODE_SLAVE  = 2'd0,
        MODE_ALIGN  = 2'd1,
        MODE_MASTER = 2'd2
    } clk_mode_e;
endpackage

// File: rtl/audio_clkgen_mode_fsm.sv
module audio_clkgen_mode_fsm
    import audio_clkgen_pkg::*;
(
    input  logic      clk_sys,
    input  logic      rst_n,
    input  logic      master_req,
    output logic      drive_en,
    output logic      div_run,
    output clk_mode_e mode
);
    clk_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SLAVE:  if (master_req) state_d = MODE_ALIGN;
            MODE_ALIGN:  state_d = master_req ? MODE_MASTER : MODE_SLAVE;
            MODE_MASTER: if (!master_req) state_d = MODE_SLAVE;
            default:     state_d = MODE_SLAVE;
        endcase
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SLAVE;
        else        state_q <= state_d;
    end

    always_comb begin
        drive_en = 1'b0;
        div_run  = 1'b0;
        unique case (state_q)
            MODE_SLAVE:  ;
            MODE_ALIGN:  ;
            MODE_MASTER: begin
                drive_en = 1'b1;
                div_run  = 1'b1;
            end
            default:     ;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/audio_clkgen_divider.sv
module audio_clkgen_divider #(
    parameter int MCK_RATIO = 256
) (
    input  logic clk_sys,
    input  logic rst_n,
    input  logic run,
    input  logic bck64,
    output logic bck_raw,
    output logic lrck_raw
);
    localparam int CNT_W  = $clog2(MCK_RATIO);
    localparam int BIT_64 = $clog2(MCK_RATIO / 64) - 1;
    localparam int BIT_32 = $clog2(MCK_RATIO / 32) - 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign bck_raw  = bck64 ? cnt_q[BIT_64] : cnt_q[BIT_32];
    assign lrck_raw = cnt_q[CNT_W-1];
endmodule

// File: rtl/audio_clkgen_watchdog.sv
module audio_clkgen_watchdog #(
    parameter int WD_W = 8
) (
    input  logic            clk_sys,
    input  logic            rst_n,
    input  logic            frame_edge,
    input  logic [WD_W-1:0] period,
    output logic            pull_low
);
    logic [WD_W-1:0] fcnt_q;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q   <= '0;
            pull_low <= 1'b0;
        end else if (period == '0) begin
            fcnt_q   <= '0;
            pull_low <= 1'b0;
        end else if (frame_edge) begin
            if (fcnt_q >= period - 1'b1) begin
                fcnt_q   <= '0;
                pull_low <= ~pull_low;
            end else begin
                fcnt_q   <= fcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int MCK_RATIO   = 256,
    parameter int WD_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_sys,
    input  logic            rst_n,
    input  logic            strap_hi,
    input  logic            cfg_master,
    input  logic            cfg_bck64,
    input  logic            cfg_mck_stop,
    input  logic [WD_W-1:0] wd_period,
    input  logic            lrck_in,
    output logic            bck_out,
    output logic            bck_oe,
    output logic            lrck_out,
    output logic            lrck_oe,
    output logic            mck_out,
    output logic            mck_oe,
    output logic            wdc_pull_low
);
    logic      drive_en, div_run, bck_raw, lrck_raw;
    clk_mode_e mode;

    audio_clkgen_mode_fsm fsm_i (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .master_req (strap_hi & cfg_master),
        .drive_en   (drive_en),
        .div_run    (div_run),
        .mode       (mode)
    );

    audio_clkgen_divider #(.MCK_RATIO(MCK_RATIO)) div_i (
        .clk_sys  (clk_sys),
        .rst_n    (rst_n),
        .run      (div_run),
        .bck64    (cfg_bck64),
        .bck_raw  (bck_raw),
        .lrck_raw (lrck_raw)
    );

    assign bck_out  = drive_en & bck_raw;
    assign lrck_out = drive_en & lrck_raw;
    assign bck_oe   = drive_en;
    assign lrck_oe  = drive_en;

    // external frame clock synchronizer
    logic [SYNC_STAGES-1:0] sync_q;
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk_sys or negedge rst_n) begin
            if (!rst_n)      sync_q[g] <= 1'b0;
            else if (g == 0) sync_q[g] <= lrck_in;
            else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
    end

    logic lrck_eff, lrck_prev_q, frame_edge;
    assign lrck_eff = (mode == MODE_MASTER) ? lrck_raw : sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) lrck_prev_q <= 1'b0;
        else        lrck_prev_q <= lrck_eff;
    end
    assign frame_edge = lrck_eff & ~lrck_prev_q;

    audio_clkgen_watchdog #(.WD_W(WD_W)) wd_i (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .frame_edge (frame_edge),
        .period     (wd_period),
        .pull_low   (wdc_pull_low)
    );

    // master-clock gate: enable updated while clk_sys is low
    logic mck_run_q;
    always_ff @(negedge clk_sys or negedge rst_n) begin
        if (!rst_n) mck_run_q <= 1'b0;
        else        mck_run_q <= strap_hi & ~cfg_mck_stop;
    end
    assign mck_out = clk_sys & mck_run_q;
    assign mck_oe  = strap_hi;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
    parameter int WD_W = 8
) (
    input logic            clk_sys,
    input logic            rst_n,
    input logic            strap_hi,
    input logic            cfg_master,
    input logic [WD_W-1:0] wd_period,
    input logic            bck_out,
    input logic            bck_oe,
    input logic            lrck_out,
    input logic            lrck_oe,
    input logic            frame_edge,
    input logic            wdc_pull_low
);
    a_r2_oe_needs_request: assert property (@(posedge clk_sys) disable iff (!rst_n)
        bck_oe |-> $past(strap_hi && cfg_master));

    a_r3_start_low: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $rose(bck_oe) |-> (!bck_out && !lrck_out));

    a_r6_lrck_on_bck_fall: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (lrck_oe && $past(lrck_oe) && (lrck_out != $past(lrck_out))) |-> $fell(bck_out));

    a_r10_wd_quiet: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (wd_period != '0 && !frame_edge) |=> $stable(wdc_pull_low));

    a_r11_wd_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (wd_period == '0) |=> !wdc_pull_low);
endmodule

bind audio_clkgen audio_clkgen_chk #(.WD_W(WD_W)) chk_i (
    .clk_sys      (clk_sys),
    .rst_n        (rst_n),
    .strap_hi     (strap_hi),
    .cfg_master   (cfg_master),
    .wd_period    (wd_period),
    .bck_out      (bck_out),
    .bck_oe       (bck_oe),
    .lrck_out     (lrck_out),
    .lrck_oe      (lrck_oe),
    .frame_edge   (frame_edge),
    .wdc_pull_low (wdc_pull_low)
);

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_W = 8;

    logic            clk_sys = 1'b0;
    logic            rst_n = 1'b0;
    logic            strap_hi = 1'b0, cfg_master = 1'b0, cfg_bck64 = 1'b1, cfg_mck_stop = 1'b0;
    logic [WD_W-1:0] wd_period = '0;
    logic            lrck_in = 1'b0;
    logic            bck_out, bck_oe, lrck_out, lrck_oe, mck_out, mck_oe, wdc_pull_low;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_sys = ~clk_sys;

    audio_clkgen dut_i (
        .clk_sys(clk_sys), .rst_n(rst_n), .strap_hi(strap_hi), .cfg_master(cfg_master),
        .cfg_bck64(cfg_bck64), .cfg_mck_stop(cfg_mck_stop), .wd_period(wd_period),
        .lrck_in(lrck_in), .bck_out(bck_out), .bck_oe(bck_oe), .lrck_out(lrck_out),
        .lrck_oe(lrck_oe), .mck_out(mck_out), .mck_oe(mck_oe), .wdc_pull_low(wdc_pull_low)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // advance to just after the next rising edge
    task automatic step();
        @(posedge clk_sys); #1;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; strap_hi = 1'b0; cfg_master = 1'b0; cfg_bck64 = 1'b1;
        cfg_mck_stop = 1'b0; wd_period = '0; lrck_in = 1'b0;
        repeat (3) step();
        @(negedge clk_sys);
        check("R1 oe in reset", bck_oe | lrck_oe, 1'b0);
        check("R1 clocks in reset", bck_out | lrck_out, 1'b0);
        rst_n = 1'b1;
        step();
        @(negedge clk_sys);
        check("R1 bck_oe after reset", bck_oe, 1'b0);
        check("R1 lrck_oe after reset", lrck_oe, 1'b0);
        check("R1 clocks after reset", bck_out | lrck_out, 1'b0);
        check("R1 watchdog after reset", wdc_pull_low, 1'b0);
    endtask

    // enter master: returns at the negedge of the first enabled cycle (k=0)
    task automatic enter_master();
        step();
        strap_hi = 1'b1; cfg_master = 1'b1;
        step();
        @(negedge clk_sys);
        check("R3 oe low during align", bck_oe, 1'b0);
        step();
        @(negedge clk_sys);
        check("R3 oe high", bck_oe, 1'b1);
        check("R3 bck starts low", bck_out, 1'b0);
        check("R3 lrck starts low", lrck_out, 1'b0);
    endtask

    task automatic test_slave_cases();
        apply_reset();
        strap_hi = 1'b0; cfg_master = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(); @(negedge clk_sys);
            check("R2 no strap oe", bck_oe | lrck_oe, 1'b0);
            check("R2 no strap clocks", bck_out | lrck_out, 1'b0);
        end
        strap_hi = 1'b1; cfg_master = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(); @(negedge clk_sys);
            check("R2 no bit oe", bck_oe | lrck_oe, 1'b0);
            check("R2 no bit clocks", bck_out | lrck_out, 1'b0);
        end
    endtask

    task automatic test_divide(input logic b64);
        apply_reset();
        cfg_bck64 = b64;
        enter_master();
        for (int k = 0; k < 600; k++) begin
            if (k > 0) begin @(posedge clk_sys); @(negedge clk_sys); end
            if (b64) check("R4 bck 64fs", bck_out, 1'((k >> 1) & 1));
            else     check("R5 bck 32fs", bck_out, 1'((k >> 2) & 1));
            check(b64 ? "R4 lrck" : "R5 lrck", lrck_out, 1'((k >> 7) & 1));
            check("R2 oe held in master", lrck_oe, 1'b1);
        end
    endtask

    task automatic test_mode_change();
        apply_reset();
        enter_master();
        repeat (50) step();
        cfg_master = 1'b0;
        @(negedge clk_sys);
        check("R7 oe before edge", bck_oe, 1'b1);
        step(); @(negedge clk_sys);
        check("R7 oe dropped", bck_oe, 1'b0);
        check("R7 lrck_oe dropped", lrck_oe, 1'b0);
        repeat (5) step();
        cfg_master = 1'b1;
        step(); step();
        @(negedge clk_sys);
        check("R7 re-entry oe", bck_oe, 1'b1);
        check("R7 re-entry bck", bck_out, 1'b0);
        for (int k = 1; k < 10; k++) begin
            @(posedge clk_sys); @(negedge clk_sys);
            check("R7 realigned count", bck_out, 1'((k >> 1) & 1));
        end
    endtask

    task automatic test_mck();
        apply_reset();
        strap_hi = 1'b1;
        step(); step();
        @(posedge clk_sys); #(CLK_PERIOD/4);
        check("R8 mck high phase", mck_out, 1'b1);
        check("R8 mck_oe", mck_oe, 1'b1);
        @(negedge clk_sys); #(CLK_PERIOD/4);
        check("R8 mck low phase", mck_out, 1'b0);
        step();
        cfg_mck_stop = 1'b1;
        @(posedge clk_sys); #(CLK_PERIOD/4);
        check("R8 mck stopped", mck_out, 1'b0);
        cfg_mck_stop = 1'b0;
        @(posedge clk_sys); #(CLK_PERIOD/4);
        check("R8 mck restarted", mck_out, 1'b1);
        step();
        strap_hi = 1'b0;
        #1;
        check("R8 mck_oe follows strap", mck_oe, 1'b0);
        @(posedge clk_sys); #(CLK_PERIOD/4);
        check("R8 mck off without strap", mck_out, 1'b0);
    endtask

    task automatic test_wd_master();
        apply_reset();
        wd_period = 8'd2;
        enter_master();
        for (int k = 0; k < 900; k++) begin
            if (k > 0) begin @(posedge clk_sys); @(negedge clk_sys); end
            check("R9 master watchdog", wdc_pull_low, (k >= 385 && k < 897) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic test_wd_slave();
        apply_reset();
        wd_period = 8'd1;
        step();
        lrck_in = 1'b1;
        step(); step();
        @(negedge clk_sys);
        check("R9 not yet toggled", wdc_pull_low, 1'b0);
        step();
        @(negedge clk_sys);
        check("R9 toggled 3 edges later", wdc_pull_low, 1'b1);
        repeat (4) step();
        lrck_in = 1'b0;
        repeat (6) step();
        for (int f = 0; f < 2; f++) begin
            lrck_in = 1'b1; repeat (6) step();
            lrck_in = 1'b0; repeat (6) step();
        end
        @(negedge clk_sys);
        check("R9 three frames toggled", wdc_pull_low, 1'b1);
        for (int i = 0; i < 300; i++) begin
            step(); @(negedge clk_sys);
            check("R10 held without frames", wdc_pull_low, 1'b1);
        end
        step();
        wd_period = '0;
        step(); @(negedge clk_sys);
        check("R11 released", wdc_pull_low, 1'b0);
        for (int f = 0; f < 3; f++) begin
            lrck_in = 1'b1; repeat (6) step();
            lrck_in = 1'b0; repeat (6) step();
            @(negedge clk_sys);
            check("R11 stays released", wdc_pull_low, 1'b0);
        end
    endtask

    initial begin
        test_slave_cases();
        test_divide(1'b1);
        test_divide(1'b0);
        test_mode_change();
        test_mck();
        test_wd_master();
        test_wd_slave();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk_sys);
                checks++; failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule